// File: doc/BRIEF.md
# Straight-Line Tape Program Sequencer

This block is the control unit of a two-register floating-point machine that runs a program from a tape with no branches. It takes one 8-bit instruction per step and sorts it into one of four kinds: a transfer between memory and the registers, an arithmetic operation, a decimal keyboard read, or a decimal display. It holds the two operand registers, drives a 64-word operand memory with one synchronous read port and one write port, and starts the external arithmetic unit and the decimal converters through start/done handshakes.

The program never names a register. A load or keyboard read fills whichever register is next in turn. An arithmetic result always replaces register one and leaves register two as the next target, so operations can be chained. A store or a display consumes the result and sends the next load back to register one. A store retires in the cycle it is accepted, and its memory write then overlaps the next instruction. A load of the address that was just stored gets the stored value from a bypass. If the arithmetic unit reports an undefined case, the whole machine freezes until reset.

Top module: `tape_seq_ctrl`

## Requirements
- R1: After a synchronous active-low reset, `instr_ready` is 1, `stopped` is 0, both registers read zero, no start strobe is raised, and the next load or read targets register one.
- R2: A store (bits 7:6 = `10`, bits 5:0 = address) writes the value of register one into the addressed memory word.
- R3: A load (bits 7:6 = `11`, bits 5:0 = address) places the addressed memory word into the target register, and the target then switches to the other register. Three loads in a row fill register one, then register two, then register one.
- R4: An arithmetic instruction (bits 7:6 = `01`) writes the unit's result into register one, and the next load or read targets register two.
- R5: A store, or a completed display, makes register one the next target.
- R6: The arithmetic sub-codes in bits 5:0 map to `alu_op` as follows, with `alu_start` a one-cycle pulse: add `100000` gives 0, subtract `101000` gives 1, multiply `001000` gives 2, divide `010000` gives 3, square root `011000` gives 4.
- R7: A keyboard read (`01111000`) pulses `kbd_start` and, on `kbd_done`, places `kbd_value` into the target register, which then switches.
- R8: A display (`01110000`) pulses `disp_start` while register one holds the value to show, and completes on `disp_done`.
- R9: A store costs no extra cycle. `instr_ready` is 1 in the cycle after acceptance, and `mem_we` with the store address is raised in that same cycle.
- R10: A load accepted in the cycle right after a store to the same address returns the stored value, not the old memory content.
- R11: A load raises `mem_re` with its address in the cycle it is accepted, and takes exactly one extra cycle before `instr_ready` returns.
- R12: `alu_done` together with `alu_halt` freezes the sequencer. `stopped` then stays 1 and `instr_ready` stays 0, and register one is left unchanged, until reset.
- R13: Codes with bits 7:6 = `00`, and codes with bits 7:6 = `01` whose sub-code is not listed in R6, R7 or R8, are no-ops. They change no register, start nothing, write no memory and cost no extra cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| instr_valid | input | 1 | Instruction byte present |
| instr_data | input | 8 | Instruction byte |
| instr_ready | output | 1 | Sequencer idle; the byte is taken at this edge |
| mem_re | output | 1 | Memory read strobe; data is expected one cycle later |
| mem_raddr | output | 6 | Memory read address |
| mem_rdata | input | DATA_W | Memory read data |
| mem_we | output | 1 | Memory write strobe |
| mem_waddr | output | 6 | Memory write address |
| mem_wdata | output | DATA_W | Memory write data |
| alu_start | output | 1 | Arithmetic start pulse |
| alu_op | output | 3 | Arithmetic operation code (R6) |
| alu_done | input | 1 | Arithmetic finished |
| alu_halt | input | 1 | Arithmetic case undefined, valid with `alu_done` |
| alu_result | input | DATA_W | Arithmetic result |
| kbd_start | output | 1 | Keyboard conversion start pulse |
| kbd_done | input | 1 | Keyboard value ready |
| kbd_value | input | DATA_W | Converted keyboard value |
| disp_start | output | 1 | Display conversion start pulse |
| disp_done | input | 1 | Display finished |
| r1 | output | DATA_W | Register one (first operand, result, display source) |
| r2 | output | DATA_W | Register two (second operand) |
| stopped | output | 1 | Machine frozen by an arithmetic halt |

## Verification
The bench builds the block with `DATA_W` = 16. At that width the bench's stand-in arithmetic unit (integer add, subtract, multiply, divide and halve) gives results that can be checked exactly, and every register and memory value can be told apart. The arithmetic unit answers three cycles after its start and the converters answer two cycles after theirs. This makes the handshake waits visible, while load, store and no-op timing stays fixed at one, zero and zero extra cycles. The memory starts filled with values unlike anything stored later. A store followed at once by a load of the same address therefore exposes a missing bypass, and a division by a zero register two exercises the freeze and its recovery through reset.

// File: rtl/tsq_pkg.sv
// Shared encodings for the tape sequencer: instruction prefixes, sub-codes,
// decoded instruction kinds and the arithmetic operation numbering.
package tsq_pkg;
    localparam int INSTR_W   = 8;
    localparam int ADDR_W    = 6;
    localparam int MEM_WORDS = 1 << ADDR_W;

    localparam logic [1:0] PFX_CTRL  = 2'b00;
    localparam logic [1:0] PFX_ARITH = 2'b01;
    localparam logic [1:0] PFX_STORE = 2'b10;
    localparam logic [1:0] PFX_LOAD  = 2'b11;

    localparam logic [5:0] SC_ADD  = 6'b100000;
    localparam logic [5:0] SC_SUB  = 6'b101000;
    localparam logic [5:0] SC_MUL  = 6'b001000;
    localparam logic [5:0] SC_DIV  = 6'b010000;
    localparam logic [5:0] SC_SQRT = 6'b011000;
    localparam logic [5:0] SC_KBD  = 6'b111000;
    localparam logic [5:0] SC_DISP = 6'b110000;

    typedef enum logic [2:0] {K_NOP, K_LOAD, K_STORE, K_ALU, K_KBD, K_DISP} kind_e;
    typedef enum logic [2:0] {
        OP_ADD = 3'd0, OP_SUB = 3'd1, OP_MUL = 3'd2, OP_DIV = 3'd3, OP_SQRT = 3'd4
    } op_e;

    typedef struct packed {
        kind_e             kind;
        op_e               op;
        logic [ADDR_W-1:0] addr;
    } dec_t;
endpackage

// File: rtl/tsq_decode.sv
// Instruction decoder.
// Turns one instruction byte into a kind, an arithmetic operation and an
// address. Assumes nothing about timing: it is purely combinational.
// Unlisted codes under prefix 00 or 01 decode as no-ops.
module tsq_decode
    import tsq_pkg::*;
(
    input  logic [INSTR_W-1:0] instr,
    output dec_t               dec
);
    // Classify the byte by prefix, then by sub-code for the 01 group.
    always_comb begin
        dec.kind = K_NOP;
        dec.op   = OP_ADD;
        dec.addr = instr[ADDR_W-1:0];
        case (instr[7:6])
            PFX_LOAD:  dec.kind = K_LOAD;
            PFX_STORE: dec.kind = K_STORE;
            PFX_ARITH: begin
                case (instr[5:0])
                    SC_ADD:  begin dec.kind = K_ALU; dec.op = OP_ADD;  end
                    SC_SUB:  begin dec.kind = K_ALU; dec.op = OP_SUB;  end
                    SC_MUL:  begin dec.kind = K_ALU; dec.op = OP_MUL;  end
                    SC_DIV:  begin dec.kind = K_ALU; dec.op = OP_DIV;  end
                    SC_SQRT: begin dec.kind = K_ALU; dec.op = OP_SQRT; end
                    SC_KBD:  dec.kind = K_KBD;
                    SC_DISP: dec.kind = K_DISP;
                    default: dec.kind = K_NOP;
                endcase
            end
            default:   dec.kind = K_NOP;
        endcase
    end
endmodule

// File: rtl/tsq_seq.sv
// Step sequencer.
// Accepts an instruction only while idle, runs the steps of each kind and
// raises one-cycle start pulses for the external units. Stores and no-ops
// retire in their accept cycle. A load spends one capture step. Handshake
// kinds wait for their done input. An arithmetic halt parks the sequencer
// in a stop state that only reset leaves.
module tsq_seq
    import tsq_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       instr_valid,
    input  dec_t       dec,
    input  logic       alu_done,
    input  logic       alu_halt,
    input  logic       kbd_done,
    input  logic       disp_done,
    output logic       instr_ready,
    output logic       accept,
    output logic       alu_start,
    output logic [2:0] alu_op,
    output logic       kbd_start,
    output logic       disp_start,
    output logic       load_cap,
    output logic       alu_fin,
    output logic       kbd_fin,
    output logic       disp_fin,
    output logic       stopped
);
    typedef enum logic [2:0] {S_IDLE, S_LOAD, S_ALU, S_KBD, S_DISP, S_STOP} state_e;

    state_e state;
    op_e    op_q;

    // Handshake and step outputs decoded from the current state.
    always_comb begin
        instr_ready = (state == S_IDLE);
        accept      = instr_valid && instr_ready;
        load_cap    = (state == S_LOAD);
        alu_fin     = (state == S_ALU) && alu_done && !alu_halt;
        kbd_fin     = (state == S_KBD) && kbd_done;
        disp_fin    = (state == S_DISP) && disp_done;
        stopped     = (state == S_STOP);
        alu_op      = op_q;
    end

    // Step register and start pulses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state      <= S_IDLE;
            op_q       <= OP_ADD;
            alu_start  <= 1'b0;
            kbd_start  <= 1'b0;
            disp_start <= 1'b0;
        end else begin
            alu_start  <= 1'b0;
            kbd_start  <= 1'b0;
            disp_start <= 1'b0;
            case (state)
                S_IDLE: begin
                    if (accept) begin
                        case (dec.kind)
                            K_LOAD: state <= S_LOAD;
                            K_ALU: begin
                                state     <= S_ALU;
                                op_q      <= dec.op;
                                alu_start <= 1'b1;
                            end
                            K_KBD: begin
                                state     <= S_KBD;
                                kbd_start <= 1'b1;
                            end
                            K_DISP: begin
                                state      <= S_DISP;
                                disp_start <= 1'b1;
                            end
                            default: state <= S_IDLE;
                        endcase
                    end
                end
                S_LOAD:  state <= S_IDLE;
                S_ALU:   if (alu_done) state <= alu_halt ? S_STOP : S_IDLE;
                S_KBD:   if (kbd_done) state <= S_IDLE;
                S_DISP:  if (disp_done) state <= S_IDLE;
                default: state <= S_STOP;
            endcase
        end
    end
endmodule

// File: rtl/tsq_regs.sv
// Operand register pair with automatic target steering.
// A load event fills the current target and flips it. A result event
// overwrites register one and points at register two. A clear event points
// back at register one. Assumes result and load never occur together.
module tsq_regs #(
    parameter int DATA_W = 21
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ld_en,
    input  logic [DATA_W-1:0] ld_val,
    input  logic              res_en,
    input  logic [DATA_W-1:0] res_val,
    input  logic              clr_tgt,
    output logic [DATA_W-1:0] r1,
    output logic [DATA_W-1:0] r2
);
    logic tgt_two;

    // Register contents and the next-target flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r1      <= '0;
            r2      <= '0;
            tgt_two <= 1'b0;
        end else begin
            if (ld_en) begin
                if (tgt_two) r2 <= ld_val;
                else         r1 <= ld_val;
                tgt_two <= !tgt_two;
            end
            if (res_en) begin
                r1      <= res_val;
                tgt_two <= 1'b1;
            end
            if (clr_tgt) tgt_two <= 1'b0;
        end
    end
endmodule

// File: rtl/tsq_wbuf.sv
// Deferred store buffer with read bypass.
// A store is latched in its accept cycle and written to memory in the next
// cycle, overlapping the following instruction. A load issued in that same
// cycle to the same address takes the buffered value instead of the memory
// read, which would still return the old word. Assumes a memory with a
// one-cycle synchronous read.
module tsq_wbuf #(
    parameter int DATA_W = 21,
    parameter int ADDR_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              st_en,
    input  logic [ADDR_W-1:0] st_addr,
    input  logic [DATA_W-1:0] st_data,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] rd_addr,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_waddr,
    output logic [DATA_W-1:0] mem_wdata,
    output logic [DATA_W-1:0] load_data
);
    logic              pend_v;
    logic [ADDR_W-1:0] pend_a;
    logic [DATA_W-1:0] pend_d;
    logic              fwd_v;
    logic [DATA_W-1:0] fwd_d;

    // Hold the pending write and note a same-address read that overlaps it.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_v <= 1'b0;
            pend_a <= '0;
            pend_d <= '0;
            fwd_v  <= 1'b0;
            fwd_d  <= '0;
        end else begin
            pend_v <= st_en;
            if (st_en) begin
                pend_a <= st_addr;
                pend_d <= st_data;
            end
            fwd_v <= rd_en && pend_v && (pend_a == rd_addr);
            fwd_d <= pend_d;
        end
    end

    // Memory write port and bypass select.
    always_comb begin
        mem_we    = pend_v;
        mem_waddr = pend_a;
        mem_wdata = pend_d;
        load_data = fwd_v ? fwd_d : mem_rdata;
    end
endmodule

// File: rtl/tape_seq_ctrl.sv
// Tape program sequencer, top level.
// Decodes instruction bytes, sequences their steps, steers loaded values
// into the register pair and drives the operand memory. Assumes external
// units answer each start pulse with a done, and that memory read data
// arrives one cycle after mem_re.
module tape_seq_ctrl
    import tsq_pkg::*;
#(
    parameter int DATA_W = 21
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               instr_valid,
    input  logic [INSTR_W-1:0] instr_data,
    output logic               instr_ready,
    output logic               mem_re,
    output logic [ADDR_W-1:0]  mem_raddr,
    input  logic [DATA_W-1:0]  mem_rdata,
    output logic               mem_we,
    output logic [ADDR_W-1:0]  mem_waddr,
    output logic [DATA_W-1:0]  mem_wdata,
    output logic               alu_start,
    output logic [2:0]         alu_op,
    input  logic               alu_done,
    input  logic               alu_halt,
    input  logic [DATA_W-1:0]  alu_result,
    output logic               kbd_start,
    input  logic               kbd_done,
    input  logic [DATA_W-1:0]  kbd_value,
    output logic               disp_start,
    input  logic               disp_done,
    output logic [DATA_W-1:0]  r1,
    output logic [DATA_W-1:0]  r2,
    output logic               stopped
);
    dec_t              dec;
    logic              accept;
    logic              load_cap;
    logic              alu_fin;
    logic              kbd_fin;
    logic              disp_fin;
    logic              st_en;
    logic              ld_en;
    logic [DATA_W-1:0] ld_val;
    logic [DATA_W-1:0] load_data;

    tsq_decode u_dec (
        .instr (instr_data),
        .dec   (dec)
    );

    tsq_seq u_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .instr_valid (instr_valid),
        .dec         (dec),
        .alu_done    (alu_done),
        .alu_halt    (alu_halt),
        .kbd_done    (kbd_done),
        .disp_done   (disp_done),
        .instr_ready (instr_ready),
        .accept      (accept),
        .alu_start   (alu_start),
        .alu_op      (alu_op),
        .kbd_start   (kbd_start),
        .disp_start  (disp_start),
        .load_cap    (load_cap),
        .alu_fin     (alu_fin),
        .kbd_fin     (kbd_fin),
        .disp_fin    (disp_fin),
        .stopped     (stopped)
    );

    // Accept-cycle strobes and the register load source.
    always_comb begin
        st_en     = accept && (dec.kind == K_STORE);
        mem_re    = accept && (dec.kind == K_LOAD);
        mem_raddr = dec.addr;
        ld_en     = load_cap || kbd_fin;
        ld_val    = load_cap ? load_data : kbd_value;
    end

    tsq_wbuf #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_wbuf (
        .clk       (clk),
        .rst_n     (rst_n),
        .st_en     (st_en),
        .st_addr   (dec.addr),
        .st_data   (r1),
        .rd_en     (mem_re),
        .rd_addr   (dec.addr),
        .mem_rdata (mem_rdata),
        .mem_we    (mem_we),
        .mem_waddr (mem_waddr),
        .mem_wdata (mem_wdata),
        .load_data (load_data)
    );

    tsq_regs #(.DATA_W(DATA_W)) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .ld_en   (ld_en),
        .ld_val  (ld_val),
        .res_en  (alu_fin),
        .res_val (alu_result),
        .clr_tgt (st_en || disp_fin),
        .r1      (r1),
        .r2      (r2)
    );
endmodule

// File: rtl/tape_seq_ctrl_chk.sv
// Protocol checker for the tape sequencer, bound to every instance.
// Watches only top-level ports.
module tape_seq_ctrl_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       instr_valid,
    input logic [7:0] instr_data,
    input logic       instr_ready,
    input logic       mem_re,
    input logic [5:0] mem_raddr,
    input logic       mem_we,
    input logic [5:0] mem_waddr,
    input logic       alu_start,
    input logic       kbd_start,
    input logic       disp_start,
    input logic       stopped
);
    logic take;
    assign take = instr_valid && instr_ready;

    // R12
    stop_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stopped |=> stopped);

    // R12
    stop_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stopped |-> !instr_ready);

    // R9
    store_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (take && instr_data[7:6] == 2'b10) |=> (mem_we && mem_waddr == $past(instr_data[5:0]) && instr_ready));

    // R11
    load_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (take && instr_data[7:6] == 2'b11) |-> (mem_re && mem_raddr == instr_data[5:0]));

    // R11
    load_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (take && instr_data[7:6] == 2'b11) |=> !instr_ready);

    // R6
    alu_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        alu_start |=> !alu_start);

    // R6
    start_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({alu_start, kbd_start, disp_start}));

    // R13
    nop_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (take && instr_data[7:6] == 2'b00) |=> (instr_ready && !mem_we && !alu_start && !kbd_start && !disp_start));
endmodule

bind tape_seq_ctrl tape_seq_ctrl_chk u_chk (.*);

// File: tb/tape_seq_ctrl_tb.sv
// Bench: behavioural model of registers, target and memory, updated per
// instruction and compared against the ports; stand-in memory and units.
module tape_seq_ctrl_tb;
    localparam int DW      = 16;
    localparam int ALU_LAT = 3;
    localparam int CNV_LAT = 2;

    logic          clk = 0;
    logic          rst_n = 0;
    logic          instr_valid = 0;
    logic [7:0]    instr_data = 0;
    logic          instr_ready, mem_re, mem_we, alu_start, kbd_start, disp_start, stopped;
    logic [5:0]    mem_raddr, mem_waddr;
    logic [DW-1:0] mem_rdata, mem_wdata, r1, r2;
    logic [2:0]    alu_op;
    logic          alu_done = 0, alu_halt = 0, kbd_done = 0, disp_done = 0;
    logic [DW-1:0] alu_result = 0, kbd_value = 0;

    tape_seq_ctrl #(.DATA_W(DW)) u_dut (.*);

    always #2 clk = ~clk;

    // Bench memory with one-cycle read.
    logic [DW-1:0] ram [64];
    initial for (int i = 0; i < 64; i++) ram[i] = DW'(i * 3 + 1);
    always @(posedge clk) begin
        if (mem_we) ram[mem_waddr] <= mem_wdata;
        if (mem_re) mem_rdata <= ram[mem_raddr];
    end

    function automatic logic [DW-1:0] alu_f(input int op, input logic [DW-1:0] a, input logic [DW-1:0] b);
        case (op)
            0: return a + b;
            1: return a - b;
            2: return a * b;
            3: return (b == 0) ? '0 : a / b;
            default: return a >> 1;
        endcase
    endfunction

    // Stand-in units, driven at the falling edge.
    int acnt = 0, kcnt = 0, dcnt = 0, aop = 0, last_op = -1;
    logic [DW-1:0] kbd_next = 0, disp_seen = 0;
    always @(negedge clk) begin
        alu_done = 0; alu_halt = 0; kbd_done = 0; disp_done = 0;
        if (alu_start) begin acnt = ALU_LAT; aop = int'(alu_op); last_op = aop; end
        else if (acnt > 0) begin
            acnt--;
            if (acnt == 0) begin
                alu_done = 1;
                alu_result = alu_f(aop, r1, r2);
                alu_halt = (aop == 3 && r2 == 0);
            end
        end
        if (kbd_start) kcnt = CNV_LAT;
        else if (kcnt > 0) begin
            kcnt--;
            if (kcnt == 0) begin kbd_done = 1; kbd_value = kbd_next; end
        end
        if (disp_start) begin dcnt = CNV_LAT; disp_seen = r1; end
        else if (dcnt > 0) begin
            dcnt--;
            if (dcnt == 0) disp_done = 1;
        end
    end

    // Reference model state.
    logic [DW-1:0] m_r1 = 0, m_r2 = 0;
    bit            m_two = 0;
    logic [DW-1:0] m_mem [64];
    initial for (int i = 0; i < 64; i++) m_mem[i] = DW'(i * 3 + 1);
    int nchk = 0, nfail = 0, cyc = 0;

    always @(posedge clk) begin
        cyc++;
        if (cyc == 100000) begin
            nfail++;
            $display("FAIL watchdog: run did not finish, act=%0d cycles exp<100000", cyc);
            $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
            $finish;
        end
    end

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s: act=%0h exp=%0h", tag, act, exp);
        end
    endtask

    task automatic cmp_regs(input string tag);
        chk(r1 == m_r1, {tag, " r1"}, r1, m_r1);
        chk(r2 == m_r2, {tag, " r2"}, r2, m_r2);
    endtask

    task automatic put(input logic [DW-1:0] v);
        if (m_two) m_r2 = v; else m_r1 = v;
        m_two = !m_two;
    endtask

    // Present one byte from a falling edge; return at the falling edge where
    // the sequencer is idle again, with the count of extra cycles.
    task automatic run(input logic [7:0] code, output int extra);
        instr_valid = 1; instr_data = code;
        while (!instr_ready) @(negedge clk);
        @(negedge clk);
        instr_valid = 0;
        extra = 0;
        while (!instr_ready && !stopped && extra < 1000) begin
            @(negedge clk);
            extra++;
        end
    endtask

    task automatic t_nop(input logic [7:0] code);
        int x;
        run(code, x);
        chk(x == 0, "R13 nop cycles", x, 0);
        cmp_regs("R13");
    endtask

    task automatic t_load(input int a);
        int x;
        run({2'b11, 6'(a)}, x);
        chk(x == 1, "R11 load cycles", x, 1);
        put(m_mem[a]);
        cmp_regs("R3");
    endtask

    task automatic t_store(input int a);
        int x;
        run({2'b10, 6'(a)}, x);
        chk(x == 0, "R9 store cycles", x, 0);
        m_mem[a] = m_r1;
        m_two = 0;
    endtask

    task automatic t_kbd(input logic [DW-1:0] v);
        int x;
        kbd_next = v;
        run(8'b01111000, x);
        put(v);
        cmp_regs("R7");
    endtask

    task automatic t_alu(input logic [7:0] code, input int op);
        int x;
        run(code, x);
        chk(last_op == op, "R6 alu_op", last_op, op);
        m_r1 = alu_f(op, m_r1, m_r2);
        m_two = 1;
        cmp_regs("R4");
    endtask

    task automatic t_disp();
        int x;
        run(8'b01110000, x);
        chk(disp_seen == m_r1, "R8 display value", disp_seen, m_r1);
        m_two = 0;
    endtask

    task automatic sweep();
        int bad = 0;
        @(negedge clk);
        for (int a = 0; a < 64; a++) if (ram[a] != m_mem[a]) bad++;
        chk(bad == 0, "R2 memory words differing", bad, 0);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 0;
        repeat (2) @(negedge clk);
        rst_n = 1;
        m_r1 = 0; m_r2 = 0; m_two = 0;
        chk(instr_ready == 1, "R1 ready", instr_ready, 1);
        chk(stopped == 0, "R1 stopped", stopped, 0);
        chk({alu_start, kbd_start, disp_start, mem_we} == 0, "R1 strobes",
            {alu_start, kbd_start, disp_start, mem_we}, 0);
        cmp_regs("R1");
    endtask

    initial begin
        int x;
        do_reset();
        // R13: no-ops under prefix 00 and unlisted 01 codes
        t_nop(8'h00); t_nop(8'h3F); t_nop(8'h40); t_nop(8'h7F);
        // R3: three loads land in R1, R2, R1
        t_load(10); t_load(20); t_load(30);
        t_kbd(16'd5);
        t_alu(8'b01100000, 0);
        // R4: load after arithmetic goes to R2
        t_load(11);
        t_alu(8'b01101000, 1);
        // R5: store sends the next read to R1
        t_store(10);
        t_kbd(16'd100);
        t_load(10);
        t_alu(8'b01001000, 2);
        // R5: display sends the next read to R1
        t_disp();
        t_kbd(16'd7);
        // R10: store then load of the same address, back to back
        t_store(20);
        t_load(20);
        chk(r1 == 16'd7, "R10 bypass value", r1, 7);
        t_load(5);
        t_alu(8'b01010000, 3);
        t_alu(8'b01011000, 4);
        t_store(63); t_store(0);
        sweep();
        // R12: divide by zero in R2 freezes the machine
        t_store(1);
        t_kbd(16'd9);
        t_kbd(16'd0);
        run(8'b01010000, x);
        chk(stopped == 1, "R12 stopped", stopped, 1);
        repeat (5) @(negedge clk);
        chk(stopped == 1, "R12 stopped held", stopped, 1);
        chk(instr_ready == 0, "R12 ready low", instr_ready, 0);
        chk(r1 == 16'd9, "R12 r1 kept", r1, 9);
        // R1: reset recovers and the first load goes to R1
        do_reset();
        t_load(10);
        sweep();
        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end
endmodule